// File: doc/BRIEF.md
# Two-Register Serial Port with Receive Queue

This block is a byte-wide asynchronous serial port that a processor reaches through two register addresses. With the register select low, a write sets the port's control fields and a read returns a status byte. With the register select high, a write hands one byte to the transmitter and a read returns the oldest received byte. Frames are 8N1: one low start bit, eight data bits least significant first, and one high stop bit.

Both serial directions are timed by one shared enable input, `baud_tick`, which pulses sixteen times per bit period. The transmitter has a single holding register in front of its shift register. The receiver feeds a small first-in first-out queue. An active-low clear-to-send input gates the start of each outgoing frame, and an active-low request-to-send output is set from the control field. A single interrupt line combines the receive and transmit conditions. Bus strobes are active low and act on their edges, so a strobe held low for several cycles counts as one access.

Top module: `acia_port`

## Requirements
- R1: After reset the port reads status 0x02 when `cts_n` is low: transmit-empty (bit 1) set, receive-full (bit 0) clear, interrupt (bit 7) clear. Status bit 2 (carrier detect) and bits 6:4 always read 0. `txd` idles high and `rts_n` is low.
- R2: With `reg_sel`=0, a write goes to control and a read returns status. With `reg_sel`=1, a write loads the transmit holding register and a read returns the receive queue head. A data write never changes the control fields.
- R3: The transmitter sends start bit 0, eight data bits LSB first and stop bit 1, each lasting 16 `baud_tick` pulses. `txd` is 1 whenever no frame is in progress.
- R4: A data write clears status bit 1 from the next cycle on. The bit stays clear while the shifter is busy and the holding register is occupied. It returns to 1 once the shifter has taken the byte.
- R5: Status bit 3 mirrors the synchronised `cts_n` level. While `cts_n` is high, no new frame starts and a pending byte stays held. Once `cts_n` goes low, the pending byte is sent.
- R6: A valid received frame pushes its data byte into the receive queue and sets status bit 0. Reading the data register returns that byte.
- R7: A low pulse on `rxd` that has returned high by mid-bit (8 ticks after the falling edge) is treated as a false start and yields no byte.
- R8: A frame whose stop bit samples low is discarded.
- R9: The receive queue holds `RXQ_DEPTH` bytes in arrival order. A data read removes the head when `rd_n` is released. A byte that arrives while the queue is full is dropped.
- R10: Control bits 6:5 select transmitter control. 10 drives `rts_n` high. 01 enables the transmit interrupt. 00 and 11 keep `rts_n` low with the transmit interrupt off. Control bit 7 enables the receive interrupt.
- R11: `irq` and status bit 7 equal (receive-interrupt-enable AND receive-full) OR (transmit-interrupt-enabled AND transmit-empty).
- R12: A control write with bits 1:0 = 11 empties the receive queue, aborts any frame in progress (`txd` returns high), empties the holding register and clears both control fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 = control/status, 1 = data |
| wr_n | input | 1 | Active-low write strobe, acts on its falling edge |
| rd_n | input | 1 | Active-low read strobe; a data read pops on its rising edge |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data (status or queue head) |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Active-low request to send |
| cts_n | input | 1 | Active-low clear to send |
| irq | output | 1 | Interrupt request, active high |

## Verification
The transmitter is exercised with alternating, single-bit and back-to-back byte patterns. These separate bit-order and bit-count faults from a holding register that loses or repeats a byte. The receiver gets a clean frame, a short glitch and a frame with a low stop bit, which show whether mid-bit start confirmation and stop checking are present. A burst of one byte more than the queue depth shows ordering and drop-on-full. A master reset issued mid-frame, with bytes queued on both sides, shows whether every piece of state is cleared.

// File: rtl/acia_pkg.sv
package acia_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    localparam logic [1:0] TC_RTS_HIGH = 2'b10;
    localparam logic [1:0] TC_TX_IRQ   = 2'b01;
    localparam logic [1:0] CR_MRESET   = 2'b11;

endpackage

// File: rtl/acia_tx.sv
module acia_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tick,
    input  logic              load_en,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              busy,
    output logic              txd
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(OVS);
    localparam int BIT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   nbit;
    } tx_state_t;

    tx_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        if (flush) begin
            state_d.busy = 1'b0;
            state_d.sh   = '1;
            state_d.cnt  = '0;
            state_d.nbit = '0;
        end else if (!state_q.busy) begin
            if (hold_valid && load_en) begin
                state_d.busy = 1'b1;
                state_d.sh   = {1'b1, hold_data, 1'b0};
                state_d.cnt  = '0;
                state_d.nbit = '0;
                take         = 1'b1;
            end
        end else if (tick) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
            if (state_q.cnt == CNT_W'(OVS - 1)) begin
                state_d.cnt  = '0;
                state_d.sh   = {1'b1, state_q.sh[FRAME_W-1:1]};
                state_d.nbit = state_q.nbit + BIT_W'(1);
                if (state_q.nbit == BIT_W'(FRAME_W - 1)) begin
                    state_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{busy: 1'b0, sh: '1, cnt: '0, nbit: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign busy = state_q.busy;
    assign txd  = state_q.busy ? state_q.sh[0] : 1'b1;

endmodule

// File: rtl/acia_rx.sv
module acia_rx
    import acia_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tick,
    input  logic              rxd_s,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    localparam int CNT_W = $clog2(OVS);
    localparam int NB_W  = $clog2(DATA_W);
    localparam int HALF  = OVS / 2;

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [NB_W-1:0]   nbit;
        logic [DATA_W-1:0] sh;
        logic              last;
    } rx_state_t;

    rx_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        valid   = 1'b0;
        if (flush) begin
            state_d.st   = RX_IDLE;
            state_d.cnt  = '0;
            state_d.last = 1'b1;
        end else if (tick) begin
            unique case (state_q.st)
                RX_IDLE: begin
                    state_d.last = rxd_s;
                    if (state_q.last && !rxd_s) begin
                        state_d.st  = RX_START;
                        state_d.cnt = '0;
                    end
                end
                RX_START: begin
                    state_d.cnt = state_q.cnt + CNT_W'(1);
                    if (state_q.cnt == CNT_W'(HALF - 1)) begin
                        state_d.cnt  = '0;
                        state_d.nbit = '0;
                        if (!rxd_s) begin
                            state_d.st = RX_DATA;
                        end else begin
                            state_d.st   = RX_IDLE;
                            state_d.last = 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    state_d.cnt = state_q.cnt + CNT_W'(1);
                    if (state_q.cnt == CNT_W'(OVS - 1)) begin
                        state_d.cnt  = '0;
                        state_d.sh   = {rxd_s, state_q.sh[DATA_W-1:1]};
                        state_d.nbit = state_q.nbit + NB_W'(1);
                        if (state_q.nbit == NB_W'(DATA_W - 1)) begin
                            state_d.st = RX_STOP;
                        end
                    end
                end
                RX_STOP: begin
                    state_d.cnt = state_q.cnt + CNT_W'(1);
                    if (state_q.cnt == CNT_W'(OVS - 1)) begin
                        state_d.cnt  = '0;
                        state_d.st   = RX_IDLE;
                        state_d.last = rxd_s;
                        valid        = rxd_s;
                    end
                end
                default: state_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{st: RX_IDLE, cnt: '0, nbit: '0, sh: '0, last: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign data = state_q.sh;

endmodule

// File: rtl/acia_rxq.sv
module acia_rxq #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CW    = PTR_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CW-1:0]                cnt;
    } q_state_t;

    q_state_t state_d, state_q;
    logic     do_push, do_pop;

    always_comb begin
        state_d = state_q;
        do_pop  = pop && (state_q.cnt != '0);
        do_push = push && ((state_q.cnt != CW'(DEPTH)) || do_pop);
        if (flush) begin
            state_d.wp  = '0;
            state_d.rp  = '0;
            state_d.cnt = '0;
        end else begin
            if (do_push) begin
                state_d.mem[state_q.wp] = push_data;
                state_d.wp              = state_q.wp + PTR_W'(1);
            end
            if (do_pop) begin
                state_d.rp = state_q.rp + PTR_W'(1);
            end
            state_d.cnt = state_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign head  = state_q.mem[state_q.rp];
    assign count = state_q.cnt;

endmodule

// File: rtl/acia_port.sv
module acia_port
    import acia_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OVS       = 16,
    parameter int RXQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              baud_tick,
    input  logic              rxd,
    output logic              txd,
    output logic              rts_n,
    input  logic              cts_n,
    output logic              irq
);
    localparam int CNT_W = $clog2(RXQ_DEPTH) + 1;

    typedef struct packed {
        logic              rie;
        logic [1:0]        tc;
        logic [DATA_W-1:0] thr;
        logic              thr_full;
        logic              wr_n_q;
        logic              rd_n_q;
        logic              rxd_m;
        logic              rxd_s;
        logic              cts_m;
        logic              cts_s;
    } port_state_t;

    port_state_t state_d, state_q;

    logic              wr_fall, rd_rise, mreset, pop;
    logic              tx_take, tx_busy;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_data, rx_head;
    logic [CNT_W-1:0]  rxq_count;
    logic              tdre, rdrf, txie, rie, cts_sync;
    logic [DATA_W-1:0] status;

    always_comb begin
        state_d        = state_q;
        wr_fall        = state_q.wr_n_q && !wr_n;
        rd_rise        = !state_q.rd_n_q && rd_n;
        mreset         = wr_fall && !reg_sel && (wdata[1:0] == CR_MRESET);
        pop            = rd_rise && reg_sel;
        state_d.wr_n_q = wr_n;
        state_d.rd_n_q = rd_n;
        state_d.rxd_m  = rxd;
        state_d.rxd_s  = state_q.rxd_m;
        state_d.cts_m  = cts_n;
        state_d.cts_s  = state_q.cts_m;
        if (tx_take) begin
            state_d.thr_full = 1'b0;
        end
        if (wr_fall && reg_sel) begin
            state_d.thr      = wdata;
            state_d.thr_full = 1'b1;
        end
        if (wr_fall && !reg_sel) begin
            if (mreset) begin
                state_d.rie      = 1'b0;
                state_d.tc       = 2'b00;
                state_d.thr_full = 1'b0;
            end else begin
                state_d.rie = wdata[7];
                state_d.tc  = wdata[6:5];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{rie: 1'b0, tc: 2'b00, thr: '0, thr_full: 1'b0,
                         wr_n_q: 1'b1, rd_n_q: 1'b1, rxd_m: 1'b1,
                         rxd_s: 1'b1, cts_m: 1'b1, cts_s: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    acia_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (mreset),
        .tick       (baud_tick),
        .load_en    (!state_q.cts_s),
        .hold_valid (state_q.thr_full),
        .hold_data  (state_q.thr),
        .take       (tx_take),
        .busy       (tx_busy),
        .txd        (txd)
    );

    acia_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (mreset),
        .tick  (baud_tick),
        .rxd_s (state_q.rxd_s),
        .valid (rx_valid),
        .data  (rx_data)
    );

    acia_rxq #(.DATA_W(DATA_W), .DEPTH(RXQ_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (mreset),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop       (pop),
        .head      (rx_head),
        .count     (rxq_count)
    );

    assign tdre     = !state_q.thr_full;
    assign rdrf     = (rxq_count != '0);
    assign txie     = (state_q.tc == TC_TX_IRQ);
    assign rie      = state_q.rie;
    assign cts_sync = state_q.cts_s;
    assign irq      = (rie && rdrf) || (txie && tdre);
    assign rts_n    = (state_q.tc == TC_RTS_HIGH);

    always_comb begin
        status    = '0;
        status[0] = rdrf;
        status[1] = tdre;
        status[3] = cts_sync;
        status[7] = irq;
    end

    assign rdata = reg_sel ? rx_head : status;

endmodule

// File: rtl/acia_port_chk.sv
module acia_port_chk #(
    parameter int DATA_W    = 8,
    parameter int RXQ_DEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_sel,
    input logic                        wr_n,
    input logic [2:0]                  cw_hi,
    input logic [1:0]                  cw_lo,
    input logic [DATA_W-1:0]           rdata,
    input logic                        txd,
    input logic                        rts_n,
    input logic                        irq,
    input logic                        tx_busy,
    input logic                        tdre,
    input logic                        cts_sync,
    input logic                        rie,
    input logic                        txie,
    input logic [$clog2(RXQ_DEPTH):0]  rxq_count
);

    p_status_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (rdata[2] == 1'b0 && rdata[6:4] == 3'b000));

    p_idle_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    p_data_wr_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) && reg_sel) |=> !tdre);

    p_tdre_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (rdata[1] == tdre));

    p_cts_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && cts_sync) |=> !tx_busy);

    p_cts_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (rdata[3] == cts_sync));

    p_rdrf_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (rdata[0] == (rxq_count != '0)));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_count <= ($clog2(RXQ_DEPTH) + 1)'(RXQ_DEPTH));

    p_rts_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) && !reg_sel && cw_hi[1:0] == 2'b10 && cw_lo != 2'b11) |=> rts_n);

    p_rie_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) && !reg_sel && cw_lo != 2'b11) |=> (rie == $past(cw_hi[2])));

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rie || txie));

    p_irq_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (rdata[7] == irq));

    p_mreset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) && !reg_sel && cw_lo == 2'b11)
        |=> (tdre && rxq_count == '0 && !tx_busy && !irq && !rts_n));

endmodule

bind acia_port acia_port_chk #(.DATA_W(DATA_W), .RXQ_DEPTH(RXQ_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .wr_n      (wr_n),
    .cw_hi     (wdata[7:5]),
    .cw_lo     (wdata[1:0]),
    .rdata     (rdata),
    .txd       (txd),
    .rts_n     (rts_n),
    .irq       (irq),
    .tx_busy   (tx_busy),
    .tdre      (tdre),
    .cts_sync  (cts_sync),
    .rie       (rie),
    .txie      (txie),
    .rxq_count (rxq_count)
);

// File: tb/test_acia_port.sv
module test_acia_port;

    localparam int TICK_DIV = 4;
    localparam int BITCLK   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic       rts_n;
    logic       cts_n = 1'b0;
    logic       irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    acia_port i_acia_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .wdata     (wdata),
        .rdata     (rdata),
        .baud_tick (baud_tick),
        .rxd       (rxd),
        .txd       (txd),
        .rts_n     (rts_n),
        .cts_n     (cts_n),
        .irq       (irq)
    );

    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic rs, logic [7:0] d);
        @(negedge clk);
        reg_sel = rs;
        wdata   = d;
        wr_n    = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(logic rs, output logic [7:0] d);
        @(negedge clk);
        reg_sel = rs;
        rd_n    = 1'b0;
        @(negedge clk);
        d    = rdata;
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_rx(logic [7:0] b, logic stop_bit);
        @(negedge clk);
        rxd = 1'b0;
        wait_clks(BITCLK);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_clks(BITCLK);
        end
        rxd = stop_bit;
        wait_clks(BITCLK);
        rxd = 1'b1;
        wait_clks(8);
    endtask

    task automatic capture_tx(output logic [7:0] b, output logic stop_ok);
        wait (txd === 1'b0);
        wait_clks(BITCLK / 2);
        for (int i = 0; i < 8; i++) begin
            wait_clks(BITCLK);
            b[i] = txd;
        end
        wait_clks(BITCLK);
        stop_ok = txd;
    endtask

    task automatic test_reset;
        logic [7:0] s;
        bus_read(1'b0, s);
        chk("R1", "status after reset", s, 8'h02);
        chk("R1", "txd idle", txd, 1'b1);
        chk("R1", "rts_n after reset", rts_n, 1'b0);
        chk("R1", "irq after reset", irq, 1'b0);
    endtask

    task automatic test_tx_patterns;
        logic [7:0] got;
        logic       stp;
        logic [7:0] s;
        logic [7:0] pats [3] = '{8'hA5, 8'h01, 8'h80};
        for (int k = 0; k < 3; k++) begin
            fork
                capture_tx(got, stp);
                bus_write(1'b1, pats[k]);
            join
            chk("R3", "tx byte", got, pats[k]);
            chk("R3", "tx stop bit", stp, 1'b1);
            wait_clks(BITCLK);
        end
        bus_read(1'b0, s);
        chk("R4", "tdre after frames", s[1], 1'b1);
    endtask

    task automatic test_tx_back2back;
        logic [7:0] a, b, s;
        logic       sa, sb;
        fork
            begin
                capture_tx(a, sa);
                capture_tx(b, sb);
            end
            begin
                bus_write(1'b1, 8'h3C);
                bus_write(1'b1, 8'hC3);
                bus_read(1'b0, s);
                chk("R4", "tdre while holding a byte", s[1], 1'b0);
            end
        join
        chk("R4", "first queued byte", a, 8'h3C);
        chk("R4", "second queued byte", b, 8'hC3);
        chk("R3", "stop bits", {sa, sb}, 2'b11);
        wait_clks(BITCLK);
        bus_read(1'b0, s);
        chk("R4", "tdre after drain", s[1], 1'b1);
    endtask

    task automatic test_cts_hold;
        logic [7:0] s, got;
        logic       stp;
        int         lows = 0;
        cts_n = 1'b1;
        wait_clks(4);
        bus_read(1'b0, s);
        chk("R5", "status with cts_n high", s, 8'h0A);
        bus_write(1'b1, 8'h5A);
        for (int i = 0; i < 3 * BITCLK; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R5", "txd low cycles while held", lows, 0);
        bus_read(1'b0, s);
        chk("R5", "tdre while held", s[1], 1'b0);
        fork
            capture_tx(got, stp);
            begin
                @(negedge clk);
                cts_n = 1'b0;
            end
        join
        chk("R5", "byte after release", got, 8'h5A);
        wait_clks(BITCLK);
    endtask

    task automatic test_reg_select;
        logic [7:0] got;
        logic       stp;
        fork
            capture_tx(got, stp);
            bus_write(1'b1, 8'h43);
        join
        chk("R2", "data write left rts_n", rts_n, 1'b0);
        chk("R2", "data write sent as byte", got, 8'h43);
        chk("R2", "data write left irq", irq, 1'b0);
        wait_clks(BITCLK);
    endtask

    task automatic test_rx_basic;
        logic [7:0] s, d;
        send_rx(8'h96, 1'b1);
        bus_read(1'b0, s);
        chk("R6", "rdrf after frame", s[0], 1'b1);
        bus_read(1'b1, d);
        chk("R6", "received byte", d, 8'h96);
        bus_read(1'b0, s);
        chk("R6", "rdrf after read", s[0], 1'b0);
    endtask

    task automatic test_rx_false_start;
        logic [7:0] s, d;
        @(negedge clk);
        rxd = 1'b0;
        wait_clks(16);
        rxd = 1'b1;
        wait_clks(11 * BITCLK);
        bus_read(1'b0, s);
        chk("R7", "rdrf after glitch", s[0], 1'b0);
        send_rx(8'h11, 1'b1);
        bus_read(1'b1, d);
        chk("R7", "byte after glitch", d, 8'h11);
    endtask

    task automatic test_rx_bad_stop;
        logic [7:0] s, d;
        send_rx(8'h77, 1'b0);
        wait_clks(BITCLK);
        bus_read(1'b0, s);
        chk("R8", "rdrf after bad stop", s[0], 1'b0);
        send_rx(8'h22, 1'b1);
        bus_read(1'b1, d);
        chk("R8", "byte after bad stop", d, 8'h22);
    endtask

    task automatic test_rx_queue;
        logic [7:0] s, d;
        for (int i = 0; i < 5; i++) send_rx(8'h10 + 8'(i), 1'b1);
        for (int i = 0; i < 4; i++) begin
            bus_read(1'b1, d);
            chk("R9", "queue order", d, 8'h10 + 8'(i));
        end
        bus_read(1'b0, s);
        chk("R9", "rdrf after draining full queue", s[0], 1'b0);
    endtask

    task automatic test_control;
        logic [7:0] s;
        bus_write(1'b0, 8'h40);
        chk("R10", "rts_n for code 10", rts_n, 1'b1);
        chk("R10", "irq for code 10", irq, 1'b0);
        bus_write(1'b0, 8'h20);
        chk("R10", "rts_n for code 01", rts_n, 1'b0);
        chk("R11", "tx irq with tdre", irq, 1'b1);
        bus_read(1'b0, s);
        chk("R11", "status with tx irq", s, 8'h82);
        bus_write(1'b0, 8'h60);
        chk("R10", "rts_n for code 11", rts_n, 1'b0);
        chk("R10", "irq for code 11", irq, 1'b0);
        bus_write(1'b0, 8'h00);
        chk("R10", "irq with code 00", irq, 1'b0);
    endtask

    task automatic test_irq_rx;
        logic [7:0] d;
        bus_write(1'b0, 8'h80);
        chk("R11", "rx irq while empty", irq, 1'b0);
        send_rx(8'hE7, 1'b1);
        chk("R11", "rx irq with data", irq, 1'b1);
        bus_read(1'b1, d);
        chk("R11", "rx irq after read", irq, 1'b0);
        bus_write(1'b0, 8'h00);
    endtask

    task automatic test_master_reset;
        logic [7:0] s;
        int         lows = 0;
        bus_write(1'b0, 8'hA0);
        send_rx(8'h31, 1'b1);
        send_rx(8'h32, 1'b1);
        bus_write(1'b1, 8'h55);
        wait_clks(100);
        bus_write(1'b1, 8'h66);
        bus_write(1'b0, 8'h03);
        chk("R12", "txd after reset write", txd, 1'b1);
        chk("R12", "irq after reset write", irq, 1'b0);
        chk("R12", "rts_n after reset write", rts_n, 1'b0);
        for (int i = 0; i < 12 * BITCLK; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R12", "txd low cycles after reset", lows, 0);
        bus_read(1'b0, s);
        chk("R12", "status after master reset", s, 8'h02);
    endtask

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        test_reset();
        test_tx_patterns();
        test_tx_back2back();
        test_cts_hold();
        test_reg_select();
        test_rx_basic();
        test_rx_false_start();
        test_rx_bad_stop();
        test_rx_queue();
        test_control();
        test_irq_rx();
        test_master_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule